// File: doc/BRIEF.md
# Keyed Flash Command Sequencer

This block sits between a register interface and a flash array. Software loads a page buffer one 32-bit word at a time, sets a byte address, and then starts an operation by writing an opcode. The opcode must arrive in the same write as a fixed 8-bit key. Four operations exist: erase a row, program a page from the buffer, lock a region and unlock a region. While an operation runs, the ready output is low. Anything written to the command, address or buffer inputs during that time is dropped and not queued.

The block also protects the array. A locked region refuses erase and program. A page may be programmed only once after its row has been erased. If either rule is broken, or the opcode is unknown, an error flag is raised and the array is left as it was. The array is an internal model of 256 rows of four 64-byte pages. It has fixed operation times and a one-cycle read port.

Byte address layout: bits [1:0] select the byte, [5:2] the word in the page, [7:6] the page in the row, [15:8] the row, and [15:12] the region. A region is 16 rows.

Top module: `flash_cmd_seq`

## Requirements
- R1: A command write (cmd_we_i) is accepted only when cmd_key_i equals 0xA5. With any other key, ready_o stays high and no flag, lock bit or array content changes.
- R2: Once a command is accepted, ready_o is low from the next cycle. It stays low for exactly 32 cycles for erase (0x02), 16 for write page (0x04), and 1 for lock (0x40), unlock (0x41) or an unknown opcode.
- R3: While ready_o is low, command, address and buffer writes are ignored. The running operation keeps its length and nothing is queued.
- R4: Erase row (0x02) sets every byte of the four pages in the addressed row to 0xFF and marks those pages blank.
- R5: Write page (0x04) copies the page buffer into the addressed page only if that page is blank since its last erase. Otherwise prog_err_o sets and the page keeps its contents. Programming clears the page's blank mark. After every write page command the buffer returns to all ones.
- R6: Lock (0x40) sets and unlock (0x41) clears bit [15:12] of the address in lock_o.
- R7: An erase or write page aimed at a locked region sets lock_err_o when it completes and leaves the array unchanged.
- R8: An accepted command with an opcode other than the four listed sets prog_err_o.
- R9: done_o sets when any accepted command completes. flag_clr_i bit 0 clears done_o, bit 1 clears lock_err_o and bit 2 clears prog_err_o. If a flag is set and cleared in the same cycle, the set wins.
- R10: After reset, ready_o is 1, all flags are 0, lock_o is 0 and no page is blank.
- R11: rd_data_o gives, one cycle after rd_addr_i, the word at bits [5:2] of that page address. Word k of a page holds the buffer word loaded at word address k, through wdata_we_i with addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_key_i | input | 8 | Key field of the command write |
| cmd_op_i | input | 8 | Opcode field of the command write |
| addr_we_i | input | 1 | Load the address register from addr_i |
| wdata_we_i | input | 1 | Store wdata_i in the page buffer at addr_i and load the address register |
| addr_i | input | 16 | Byte address |
| wdata_i | input | 32 | Page buffer write data |
| flag_clr_i | input | 3 | Write-one-to-clear for done, lock error and program error |
| rd_addr_i | input | 16 | Array read byte address |
| rd_data_o | output | 32 | Array read data, one cycle latency |
| ready_o | output | 1 | High when no command is running |
| done_o | output | 1 | Command completion flag |
| lock_err_o | output | 1 | Locked-region access flag |
| prog_err_o | output | 1 | Program-rule or opcode error flag |
| lock_o | output | 16 | Per-region lock bits |

## Verification
A duration counter loaded with the wrong value, or reloaded by a dropped command, shows up at once as a low period on ready_o of the wrong length. The bench counts that period exactly for every opcode and for a command written during busy. Errors in the blank or lock state do not appear until the next erase or program of that page. That command then finishes with a wrong error flag, and the read port returns data that was changed or not changed when it should not have been. So every scenario reads the array back right after completion. An address decode that picks the wrong row, page or region is caught by the last-row, last-page and last-region cases.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [7:0] {
    OP_ERASE  = 8'h02,
    OP_WRITE  = 8'h04,
    OP_LOCK   = 8'h40,
    OP_UNLOCK = 8'h41
  } fcs_op_e;

  localparam int unsigned FLAG_DONE = 0;
  localparam int unsigned FLAG_LERR = 1;
  localparam int unsigned FLAG_PERR = 2;
endpackage

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
  import fcs_pkg::*;
#(
  parameter logic [7:0] KEY        = 8'hA5,
  parameter int unsigned ERASE_CYC = 32,
  parameter int unsigned WRITE_CYC = 16,
  localparam int unsigned MAX_CYC  = (ERASE_CYC > WRITE_CYC) ? ERASE_CYC : WRITE_CYC,
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_we_i,
  input  logic [7:0] cmd_key_i,
  input  logic [7:0] cmd_op_i,
  input  logic       lock_hit_i,
  input  logic       page_blank_i,
  input  logic [2:0] flag_clr_i,
  output logic       busy_o,
  output logic       erase_go_o,
  output logic       write_go_o,
  output logic       lock_set_o,
  output logic       lock_clr_o,
  output logic       pbuf_clr_o,
  output logic [2:0] flags_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] dur;
  logic [7:0]       op_q;
  logic [2:0]       flags_q;
  logic             accept, fin;
  logic             is_erase, is_write, is_lock, is_unlock, op_valid;
  logic [2:0]       flag_set;

  assign accept = cmd_we_i && !busy_q && (cmd_key_i == KEY);

  always_comb begin
    unique case (cmd_op_i)
      OP_ERASE: dur = CNT_W'(ERASE_CYC - 1);
      OP_WRITE: dur = CNT_W'(WRITE_CYC - 1);
      default:  dur = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= dur;
      op_q   <= cmd_op_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign fin       = busy_q && (cnt_q == '0);
  assign is_erase  = (op_q == OP_ERASE);
  assign is_write  = (op_q == OP_WRITE);
  assign is_lock   = (op_q == OP_LOCK);
  assign is_unlock = (op_q == OP_UNLOCK);
  assign op_valid  = is_erase | is_write | is_lock | is_unlock;

  assign erase_go_o = fin && is_erase && !lock_hit_i;
  assign write_go_o = fin && is_write && !lock_hit_i && page_blank_i;
  assign lock_set_o = fin && is_lock;
  assign lock_clr_o = fin && is_unlock;
  assign pbuf_clr_o = fin && is_write;

  always_comb begin
    flag_set            = '0;
    flag_set[FLAG_DONE] = fin;
    flag_set[FLAG_LERR] = fin && (is_erase || is_write) && lock_hit_i;
    flag_set[FLAG_PERR] = fin && (!op_valid || (is_write && !lock_hit_i && !page_blank_i));
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flag_set | (flags_q & ~flag_clr_i);
  end

  assign busy_o  = busy_q;
  assign flags_o = flags_q;

  assert_accept_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_q);
  assert_busy_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !fin) |=> (busy_q && $stable(op_q)));
  assert_done_after_fin_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin |=> flags_q[FLAG_DONE]);
endmodule

// File: rtl/fcs_lock.sv
module fcs_lock #(
  parameter int unsigned NUM_REGIONS = 16,
  localparam int unsigned REG_W      = $clog2(NUM_REGIONS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [REG_W-1:0]       region_i,
  input  logic                   set_i,
  input  logic                   clr_i,
  output logic                   hit_o,
  output logic [NUM_REGIONS-1:0] lock_o
);
  logic [NUM_REGIONS-1:0] lock_q;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            lock_q[g] <= 1'b0;
      else if (set_i && region_i == REG_W'(g)) lock_q[g] <= 1'b1;
      else if (clr_i && region_i == REG_W'(g)) lock_q[g] <= 1'b0;
    end
  end

  assign hit_o  = lock_q[region_i];
  assign lock_o = lock_q;
endmodule

// File: rtl/fcs_pagebuf.sv
module fcs_pagebuf #(
  parameter int unsigned WORDS  = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned WI_W  = $clog2(WORDS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [WI_W-1:0]         widx_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic                    clr_i,
  output logic [WORDS*DATA_W-1:0] page_o
);
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           word_q <= '1;
      else if (clr_i)                        word_q <= '1;
      else if (we_i && widx_i == WI_W'(g))   word_q <= wdata_i;
    end
    assign page_o[g*DATA_W +: DATA_W] = word_q;
  end
endmodule

// File: rtl/fcs_array.sv
module fcs_array #(
  parameter int unsigned NUM_ROWS      = 256,
  parameter int unsigned PAGES_PER_ROW = 4,
  parameter int unsigned WORDS         = 16,
  parameter int unsigned DATA_W        = 32,
  localparam int unsigned NUM_PAGES    = NUM_ROWS * PAGES_PER_ROW,
  localparam int unsigned PAGE_BITS    = WORDS * DATA_W,
  localparam int unsigned ROW_W        = $clog2(NUM_ROWS),
  localparam int unsigned PG_W         = $clog2(NUM_PAGES),
  localparam int unsigned PIR_W        = $clog2(PAGES_PER_ROW),
  localparam int unsigned WI_W         = $clog2(WORDS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 erase_go_i,
  input  logic [ROW_W-1:0]     erase_row_i,
  input  logic                 write_go_i,
  input  logic [PG_W-1:0]      page_i,
  input  logic [PAGE_BITS-1:0] wpage_i,
  output logic                 blank_o,
  input  logic [PG_W-1:0]      rd_page_i,
  input  logic [WI_W-1:0]      rd_word_i,
  output logic [DATA_W-1:0]    rd_data_o
);
  logic [PAGE_BITS-1:0] mem [NUM_PAGES];
  logic [NUM_PAGES-1:0] blank_q;
  logic [DATA_W-1:0]    rd_q;

  always_ff @(posedge clk_i) begin
    if (erase_go_i) begin
      for (int k = 0; k < PAGES_PER_ROW; k++)
        mem[{erase_row_i, PIR_W'(k)}] <= '1;
    end else if (write_go_i) begin
      mem[page_i] <= wpage_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blank_q <= '0;
    end else if (erase_go_i) begin
      for (int k = 0; k < PAGES_PER_ROW; k++)
        blank_q[{erase_row_i, PIR_W'(k)}] <= 1'b1;
    end else if (write_go_i) begin
      blank_q[page_i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= mem[rd_page_i][rd_word_i*DATA_W +: DATA_W];
  end

  assign blank_o   = blank_q[page_i];
  assign rd_data_o = rd_q;

  assert_prog_blank_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    write_go_i |=> !blank_q[$past(page_i)]);
  assert_erase_marks_blank_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_go_i |=> blank_q[{$past(erase_row_i), PIR_W'(0)}]);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter logic [7:0]  KEY             = 8'hA5,
  parameter int unsigned PAGE_BYTES      = 64,
  parameter int unsigned PAGES_PER_ROW   = 4,
  parameter int unsigned ROWS_PER_REGION = 16,
  parameter int unsigned NUM_ROWS        = 256,
  parameter int unsigned ERASE_CYC       = 32,
  parameter int unsigned WRITE_CYC       = 16,
  parameter int unsigned DATA_W          = 32,
  localparam int unsigned WORDS       = PAGE_BYTES / (DATA_W / 8),
  localparam int unsigned NUM_REGIONS = NUM_ROWS / ROWS_PER_REGION,
  localparam int unsigned NUM_PAGES   = NUM_ROWS * PAGES_PER_ROW,
  localparam int unsigned ADDR_W      = $clog2(NUM_PAGES * PAGE_BYTES),
  localparam int unsigned BYTE_W      = $clog2(DATA_W / 8),
  localparam int unsigned WI_W        = $clog2(WORDS),
  localparam int unsigned OFF_W       = $clog2(PAGE_BYTES),
  localparam int unsigned PG_W        = $clog2(NUM_PAGES),
  localparam int unsigned ROW_W       = $clog2(NUM_ROWS),
  localparam int unsigned REG_W       = $clog2(NUM_REGIONS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cmd_we_i,
  input  logic [7:0]             cmd_key_i,
  input  logic [7:0]             cmd_op_i,
  input  logic                   addr_we_i,
  input  logic                   wdata_we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic [2:0]             flag_clr_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic                   ready_o,
  output logic                   done_o,
  output logic                   lock_err_o,
  output logic                   prog_err_o,
  output logic [NUM_REGIONS-1:0] lock_o
);
  logic                  busy;
  logic [ADDR_W-1:0]     addr_q;
  logic                  erase_go, write_go, lock_set, lock_clr, pbuf_clr;
  logic                  lock_hit, page_blank;
  logic [2:0]            flags;
  logic [WORDS*DATA_W-1:0] pbuf;

  wire [PG_W-1:0]  page_sel   = addr_q[ADDR_W-1 -: PG_W];
  wire [ROW_W-1:0] row_sel    = addr_q[ADDR_W-1 -: ROW_W];
  wire [REG_W-1:0] region_sel = addr_q[ADDR_W-1 -: REG_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  addr_q <= '0;
    else if (!busy && (addr_we_i || wdata_we_i))  addr_q <= addr_i;
  end

  fcs_ctrl #(.KEY(KEY), .ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC)) u_ctrl (
    .clk_i, .rst_ni, .cmd_we_i, .cmd_key_i, .cmd_op_i,
    .lock_hit_i(lock_hit), .page_blank_i(page_blank), .flag_clr_i,
    .busy_o(busy), .erase_go_o(erase_go), .write_go_o(write_go),
    .lock_set_o(lock_set), .lock_clr_o(lock_clr), .pbuf_clr_o(pbuf_clr),
    .flags_o(flags)
  );

  fcs_lock #(.NUM_REGIONS(NUM_REGIONS)) u_lock (
    .clk_i, .rst_ni, .region_i(region_sel), .set_i(lock_set), .clr_i(lock_clr),
    .hit_o(lock_hit), .lock_o(lock_o)
  );

  fcs_pagebuf #(.WORDS(WORDS), .DATA_W(DATA_W)) u_pbuf (
    .clk_i, .rst_ni, .we_i(wdata_we_i && !busy),
    .widx_i(addr_i[OFF_W-1:BYTE_W]), .wdata_i, .clr_i(pbuf_clr), .page_o(pbuf)
  );

  fcs_array #(.NUM_ROWS(NUM_ROWS), .PAGES_PER_ROW(PAGES_PER_ROW),
              .WORDS(WORDS), .DATA_W(DATA_W)) u_array (
    .clk_i, .rst_ni, .erase_go_i(erase_go), .erase_row_i(row_sel),
    .write_go_i(write_go), .page_i(page_sel), .wpage_i(pbuf), .blank_o(page_blank),
    .rd_page_i(rd_addr_i[ADDR_W-1 -: PG_W]), .rd_word_i(rd_addr_i[OFF_W-1:BYTE_W]),
    .rd_data_o
  );

  assign ready_o    = !busy;
  assign done_o     = flags[FLAG_DONE];
  assign lock_err_o = flags[FLAG_LERR];
  assign prog_err_o = flags[FLAG_PERR];

  assert_bad_key_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && ready_o && cmd_key_i != KEY) |=> ready_o);
  assert_good_key_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && ready_o && cmd_key_i == KEY) |=> !ready_o);
  assert_locked_untouched_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_go || write_go) |-> !lock_o[region_sel]);
  assert_addr_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(addr_q));
endmodule

// File: tb/tb_flash_cmd_seq.sv
`timescale 1ns/1ps
module tb_flash_cmd_seq;
  localparam logic [7:0] KEY = 8'hA5;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_we = 0, addr_we = 0, wdata_we = 0;
  logic [7:0] key = 0, op = 0;
  logic [15:0] addr = 0, rd_addr = 0;
  logic [31:0] wdata = 0, rd_data;
  logic [2:0] flag_clr = 0;
  logic ready, done, lerr, perr;
  logic [15:0] lock;
  int errs = 0, checks = 0;
  bit fin = 0;

  always #5 clk = ~clk;

  flash_cmd_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_key_i(key), .cmd_op_i(op),
    .addr_we_i(addr_we), .wdata_we_i(wdata_we), .addr_i(addr), .wdata_i(wdata),
    .flag_clr_i(flag_clr), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .ready_o(ready), .done_o(done), .lock_err_o(lerr), .prog_err_o(perr), .lock_o(lock)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_addr(input logic [15:0] a);
    addr = a; addr_we = 1; @(negedge clk); addr_we = 0;
  endtask

  // issue command, return number of cycles ready stayed low
  task automatic run_cmd(input logic [7:0] k, input logic [7:0] o, output int cyc);
    key = k; op = o; cmd_we = 1; @(negedge clk); cmd_we = 0;
    cyc = 0;
    while (!ready && cyc < 100) begin cyc++; @(negedge clk); end
  endtask

  task automatic clr_flags();
    flag_clr = 3'b111; @(negedge clk); flag_clr = 0;
  endtask

  function automatic logic [31:0] pat(input int pg, input int w, input int s);
    return 32'hC0DE_0000 ^ (pg << 8) ^ w ^ (s << 20);
  endfunction

  task automatic load_page(input int pg, input int s);
    for (int w = 0; w < 16; w++) begin
      addr = 16'(pg * 64 + w * 4); wdata = pat(pg, w, s); wdata_we = 1;
      @(negedge clk);
    end
    wdata_we = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    rd_addr = a; @(negedge clk); d = rd_data;
  endtask

  task automatic t_reset();
    chk(ready == 1, "R10 ready", 32'(ready), 1);
    chk({done, lerr, perr} == 0, "R10 flags", 32'({done, lerr, perr}), 0);
    chk(lock == 0, "R10 lock", 32'(lock), 0);
  endtask

  task automatic t_bad_key();
    int c;
    set_addr(16'h0500);
    run_cmd(8'h5A, 8'h02, c);
    chk(c == 0, "R1 ready after bad key", 32'(c), 0);
    repeat (40) @(negedge clk);
    chk(done == 0, "R1 no done", 32'(done), 0);
    // unerased page after reset: program refused
    load_page(20, 0);
    run_cmd(KEY, 8'h04, c);
    chk(c == 16, "R2 write length", 32'(c), 16);
    chk(perr == 1, "R5 R10 write to non-blank", 32'(perr), 1);
    chk(done == 1, "R9 done on write", 32'(done), 1);
    clr_flags();
    chk({done, lerr, perr} == 0, "R9 clear all", 32'({done, lerr, perr}), 0);
  endtask

  task automatic t_erase();
    int c; logic [31:0] d;
    set_addr(16'h0200);
    run_cmd(KEY, 8'h02, c);
    chk(c == 32, "R2 erase length", 32'(c), 32);
    chk(done == 1 && lerr == 0 && perr == 0, "R9 erase flags", 32'({done, lerr, perr}), 3'b100);
    rd(16'h02FC, d);
    chk(d == 32'hFFFF_FFFF, "R4 erased word", d, 32'hFFFF_FFFF);
    clr_flags();
  endtask

  task automatic t_busy_drop();
    int c;
    set_addr(16'h0300);
    key = KEY; op = 8'h02; cmd_we = 1; @(negedge clk); cmd_we = 0;
    c = 0;
    repeat (3) begin c++; @(negedge clk); end
    key = KEY; op = 8'h40; cmd_we = 1; addr = 16'h5000; addr_we = 1;
    c++; @(negedge clk); cmd_we = 0; addr_we = 0;
    while (!ready && c < 100) begin c++; @(negedge clk); end
    chk(c == 32, "R3 length unchanged", 32'(c), 32);
    repeat (3) @(negedge clk);
    chk(ready == 1, "R3 no queued command", 32'(ready), 1);
    chk(lock == 0, "R3 lock dropped", 32'(lock), 0);
    clr_flags();
  endtask

  task automatic t_write();
    int c; logic [31:0] d; bit ok = 1;
    load_page(9, 1);
    run_cmd(KEY, 8'h04, c);
    chk(c == 16, "R2 write length", 32'(c), 16);
    chk(perr == 0 && lerr == 0, "R5 no error", 32'({lerr, perr}), 0);
    for (int w = 0; w < 16; w++) begin
      rd(16'(9 * 64 + w * 4), d);
      if (d != pat(9, w, 1)) begin ok = 0; chk(0, "R11 R5 word", d, pat(9, w, 1)); end
    end
    if (ok) chk(1, "R11 page", 0, 0);
    clr_flags();
    load_page(9, 2);
    run_cmd(KEY, 8'h04, c);
    chk(perr == 1, "R5 second program refused", 32'(perr), 1);
    rd(16'(9 * 64 + 12), d);
    chk(d == pat(9, 3, 1), "R5 data kept", d, pat(9, 3, 1));
    clr_flags();
  endtask

  task automatic t_lock();
    int c; logic [31:0] d;
    set_addr(16'h0000);
    run_cmd(KEY, 8'h40, c);
    chk(c == 1, "R2 lock length", 32'(c), 1);
    chk(lock == 16'h0001, "R6 lock bit", 32'(lock), 1);
    set_addr(16'h0200);
    run_cmd(KEY, 8'h02, c);
    chk(lerr == 1 && done == 1, "R7 lock error", 32'({lerr, done}), 3);
    rd(16'(9 * 64 + 4), d);
    chk(d == pat(9, 1, 1), "R7 array unchanged", d, pat(9, 1, 1));
    clr_flags();
    run_cmd(KEY, 8'h41, c);
    chk(c == 1 && lock == 0, "R6 unlock", 32'(lock), 0);
    run_cmd(KEY, 8'h02, c);
    rd(16'(9 * 64 + 4), d);
    chk(d == 32'hFFFF_FFFF && lerr == 0, "R4 erase after unlock", d, 32'hFFFF_FFFF);
    clr_flags();
  endtask

  task automatic t_invalid();
    int c;
    run_cmd(KEY, 8'h13, c);
    chk(c == 1, "R2 invalid length", 32'(c), 1);
    chk(perr == 1 && lerr == 0, "R8 invalid opcode", 32'({lerr, perr}), 1);
    flag_clr = 3'b001; @(negedge clk); flag_clr = 0;
    chk(done == 0 && perr == 1, "R9 selective clear", 32'({done, perr}), 1);
    flag_clr = 3'b100; @(negedge clk); flag_clr = 0;
    chk(perr == 0, "R9 perr clear", 32'(perr), 0);
  endtask

  task automatic t_last();
    int c; logic [31:0] d;
    set_addr(16'hFF00);
    run_cmd(KEY, 8'h02, c);
    chk(c == 32 && lerr == 0, "R4 last row erase", 32'(c), 32);
    load_page(1023, 3);
    run_cmd(KEY, 8'h04, c);
    chk(perr == 0, "R5 last page", 32'(perr), 0);
    rd(16'hFFFC, d);
    chk(d == pat(1023, 15, 3), "R11 last word", d, pat(1023, 15, 3));
    rd(16'hFF3C, d);
    chk(d == 32'hFFFF_FFFF, "R4 neighbour page blank", d, 32'hFFFF_FFFF);
    run_cmd(KEY, 8'h40, c);
    chk(lock == 16'h8000, "R6 last region", 32'(lock), 32'h8000);
    run_cmd(KEY, 8'h04, c);
    chk(lerr == 1, "R7 write to locked", 32'(lerr), 1);
    run_cmd(KEY, 8'h41, c);
    clr_flags();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_bad_key();
    t_erase();
    t_busy_drop();
    t_write();
    t_lock();
    t_invalid();
    t_last();
    fin = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!fin) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule